// File: doc/BRIEF.md
# Partial-Store Edge Mask Unit

This unit takes a start byte address and an end byte address, both 64 bits wide, and produces the lane-enable mask for a partial store into the aligned 8-byte word that contains the start address. Elements may be 8, 16 or 32 bits wide, so the mask has 8, 4 or 2 meaningful bits. Lanes can be numbered in big-endian order (lane 0 in the most significant mask bit) or in little-endian order (lane 0 in the least significant bit). Lanes below the start offset are disabled. When both addresses fall in the same aligned word, lanes beyond the end offset are disabled too.

A 4-bit function code selects the element width, the lane order and whether integer condition flags are written. A flag-writing operation updates two flag sets, one for the low 32 bits and one for all 64 bits. Each set holds the N, Z, V and C results of subtracting the end address from the start address. A 32-bit address mode makes the same-word test ignore the upper half of the addresses. Every accepted operation produces its result one clock later.

Top module: `edge_mask_unit`

## Requirements
- R1: Function code decode: bits [3:2] select the element width (00 = 8, 01 = 16, 10 = 32 bits), bit 1 set selects little-endian lane order, and bit 0 set suppresses the flag update.
- R2: 8-bit elements, big-endian (offset k = addr[2:0]): the start mask is 0xFF >> k and the end mask keeps the top k+1 bits.
- R3: 8-bit elements, little-endian: the start mask is (0xFF << k) truncated to 8 bits and the end mask keeps the low k+1 bits.
- R4: 16-bit elements (offset j = addr[2:1]): big-endian start masks are F,7,3,1 and end masks are 8,C,E,F; little-endian start masks are F,E,C,8 and end masks are 1,3,7,F.
- R5: 32-bit elements (offset m = addr[2]): big-endian start masks are 3,1 and end masks are 2,3; little-endian start masks are 3,2 and end masks are 1,3.
- R6: The result is the start mask ANDed with the end mask when both addresses are equal with bits [2:0] cleared, and the start mask alone otherwise.
- R7: When addr32 is high, bits [63:32] of both addresses are ignored in the same-word test.
- R8: An operation accepted with in_valid high is reflected on the next cycle with out_valid high. mask_out is zero-extended to 64 bits, and it is all zero in any cycle where out_valid is low.
- R9: A flag-writing operation loads xcc = {N,Z,V,C} of the 64-bit result src_a - src_b: N is bit 63, Z is a zero result, V is signed overflow, and C is the unsigned borrow (src_a < src_b).
- R10: The same operation loads icc = {N,Z,V,C} computed in the same way from the low 32 bits of both operands.
- R11: Operations with bit 0 of the code set leave icc and xcc unchanged, and so do idle cycles.
- R12: Codes 0xC to 0xF raise out_illegal with out_valid, give a zero mask and leave the flags unchanged.
- R13: After reset, out_valid, out_illegal, mask_out, icc and xcc are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request |
| func | input | 4 | Function code |
| src_a | input | 64 | Start address |
| src_b | input | 64 | End address |
| addr32 | input | 1 | 32-bit address mode |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | Undefined function code seen |
| mask_out | output | 64 | Zero-extended lane mask |
| icc | output | 4 | 32-bit flags {N,Z,V,C} |
| xcc | output | 4 | 64-bit flags {N,Z,V,C} |

## Verification
The bench covers every pair of start and end offsets, in the same word and in different words, for every width and both lane orders. A design that reversed the lane order, clipped lanes one position off, or applied the end mask across a word boundary would show a wrong mask. In 32-bit address mode the addresses differ only above bit 31, which exposes a same-word test that does not truncate. Operand pairs with signed overflow, equal values and borrow in only one half separate the two flag sets. Non-writing and illegal codes placed between writing ones would reveal flags that drift when they should hold.

// File: rtl/edge_pkg.sv
package edge_pkg;
  localparam int ADDR_W   = 64;
  localparam int WORD_B   = 8;
  localparam int OFF_W    = $clog2(WORD_B);
  localparam int NUM_WID  = 3;
  localparam int FLAG_W   = 4;

  typedef enum logic [1:0] {
    ELEM_8  = 2'b00,
    ELEM_16 = 2'b01,
    ELEM_32 = 2'b10,
    ELEM_XX = 2'b11
  } elem_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;
endpackage

// File: rtl/edge_decode.sv
module edge_decode
  import edge_pkg::*;
(
  input  logic [3:0] func,
  output elem_t      elem,
  output logic       little,
  output logic       cc_en,
  output logic       illegal
);
  always_comb begin
    elem    = elem_t'(func[3:2]);
    little  = func[1];
    illegal = (func[3:2] == 2'b11);
    cc_en   = !func[0] && !illegal;
  end
endmodule

// File: rtl/edge_lane_mask.sv
module edge_lane_mask #(
  parameter int LANES = 8,
  localparam int OW = $clog2(LANES)
) (
  input  logic [OW-1:0]    off_s,
  input  logic [OW-1:0]    off_e,
  input  logic             little,
  input  logic             same_word,
  output logic [LANES-1:0] mask
);
  localparam logic [LANES-1:0] ONES = {LANES{1'b1}};

  logic [OW:0]       end_cnt;
  logic [LANES-1:0]  start_m;
  logic [LANES-1:0]  end_m;

  always_comb begin
    end_cnt = {1'b0, off_e} + 1'b1;
    if (little) begin
      start_m = ONES << off_s;
      end_m   = ~(ONES << end_cnt);
    end else begin
      start_m = ONES >> off_s;
      end_m   = ~(ONES >> end_cnt);
    end
    mask = same_word ? (start_m & end_m) : start_m;
  end
endmodule

// File: rtl/edge_flags.sv
module edge_flags
  import edge_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output nzvc_t        flags
);
  logic [W:0] diff;

  always_comb begin
    diff    = {1'b0, op_a} - {1'b0, op_b};
    flags.n = diff[W-1];
    flags.z = (diff[W-1:0] == '0);
    flags.v = (op_a[W-1] != op_b[W-1]) && (diff[W-1] != op_a[W-1]);
    flags.c = diff[W];
  end
endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
  import edge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        func,
  input  logic [ADDR_W-1:0] src_a,
  input  logic [ADDR_W-1:0] src_b,
  input  logic              addr32,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [ADDR_W-1:0] mask_out,
  output logic [FLAG_W-1:0] icc,
  output logic [FLAG_W-1:0] xcc
);
  elem_t elem;
  logic  little, cc_en, illegal;
  logic  same_word;
  nzvc_t f32, f64;

  logic [WORD_B-1:0] lane_m [NUM_WID];
  logic [WORD_B-1:0] sel_m;

  logic              nxt_valid, nxt_illegal, flag_upd;
  logic [ADDR_W-1:0] nxt_mask;
  logic [FLAG_W-1:0] nxt_icc, nxt_xcc;

  edge_decode u_dec (
    .func(func), .elem(elem), .little(little), .cc_en(cc_en), .illegal(illegal)
  );

  always_comb begin
    if (addr32)
      same_word = (src_a[31:OFF_W] == src_b[31:OFF_W]);
    else
      same_word = (src_a[ADDR_W-1:OFF_W] == src_b[ADDR_W-1:OFF_W]);
  end

  for (genvar g = 0; g < NUM_WID; g++) begin : g_wid
    localparam int LN = WORD_B >> g;
    localparam int OW = $clog2(LN);
    logic [LN-1:0] m;
    edge_lane_mask #(.LANES(LN)) u_lane (
      .off_s(src_a[OFF_W-1 -: OW]),
      .off_e(src_b[OFF_W-1 -: OW]),
      .little(little),
      .same_word(same_word),
      .mask(m)
    );
    assign lane_m[g] = WORD_B'(m);
  end

  edge_flags #(.W(32)) u_f32 (.op_a(src_a[31:0]), .op_b(src_b[31:0]), .flags(f32));
  edge_flags #(.W(ADDR_W)) u_f64 (.op_a(src_a), .op_b(src_b), .flags(f64));

  always_comb begin
    case (elem)
      ELEM_8:  sel_m = lane_m[0];
      ELEM_16: sel_m = lane_m[1];
      ELEM_32: sel_m = lane_m[2];
      default: sel_m = '0;
    endcase
  end

  always_comb begin
    nxt_valid   = in_valid;
    nxt_illegal = in_valid && illegal;
    nxt_mask    = (in_valid && !illegal) ? ADDR_W'(sel_m) : '0;
    flag_upd    = in_valid && cc_en;
    nxt_icc     = flag_upd ? f32 : icc;
    nxt_xcc     = flag_upd ? f64 : xcc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      mask_out    <= '0;
      icc         <= '0;
      xcc         <= '0;
    end else begin
      out_valid   <= nxt_valid;
      out_illegal <= nxt_illegal;
      mask_out    <= nxt_mask;
      if (flag_upd) begin
        icc <= nxt_icc;
        xcc <= nxt_xcc;
      end
    end
  end
endmodule

// File: rtl/edge_mask_unit_chk.sv
module edge_mask_unit_chk
  import edge_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        func,
  input logic [ADDR_W-1:0] src_a,
  input logic [ADDR_W-1:0] src_b,
  input logic              addr32,
  input logic              out_valid,
  input logic              out_illegal,
  input logic [ADDR_W-1:0] mask_out,
  input logic [FLAG_W-1:0] icc,
  input logic [FLAG_W-1:0] xcc
);
  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  idle_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (mask_out == '0));
  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_out[ADDR_W-1:WORD_B] == '0);
  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || func[0] || func[3:2] == 2'b11) |=> ($stable(icc) && $stable(xcc)));
  // R12
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func[3:2] == 2'b11) |=> out_illegal);
  // R12
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (mask_out == '0 && out_valid));
  // R9
  borrow64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !func[0] && func[3:2] != 2'b11) |=> (xcc[0] == ($past(src_a) < $past(src_b))));
  // R10
  zero32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !func[0] && func[3:2] != 2'b11) |=> (icc[2] == ($past(src_a[31:0]) == $past(src_b[31:0]))));
endmodule

bind edge_mask_unit edge_mask_unit_chk u_chk (.*);

// File: tb/edge_mask_unit_test.sv
`timescale 1ns/1ps
module edge_mask_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  func;
  logic [63:0] src_a, src_b;
  logic        addr32;
  logic        out_valid, out_illegal;
  logic [63:0] mask_out;
  logic [3:0]  icc, xcc;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_icc = 4'h0;
  logic [3:0] exp_xcc = 4'h0;

  always #2.5 clk = ~clk;

  edge_mask_unit uut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_mask(int wsel, bit le, logic [63:0] a, logic [63:0] b, bit m32);
    int eb = 1 << wsel;
    int n  = 8 / eb;
    int os = int'(a[2:0]) / eb;
    int oe = int'(b[2:0]) / eb;
    bit same = m32 ? (a[31:3] == b[31:3]) : (a[63:3] == b[63:3]);
    logic [7:0] m = '0;
    for (int l = 0; l < n; l++)
      if (l >= os && (!same || l <= oe))
        m[le ? l : n - 1 - l] = 1'b1;
    return m;
  endfunction

  function automatic logic [3:0] ref_flags64(logic [63:0] a, logic [63:0] b);
    logic [63:0] d = a - b;
    bit lt = $signed(a) < $signed(b);
    return {d[63], d == 64'd0, lt ^ d[63], a < b};
  endfunction

  function automatic logic [3:0] ref_flags32(logic [31:0] a, logic [31:0] b);
    logic [31:0] d = a - b;
    bit lt = $signed(a) < $signed(b);
    return {d[31], d == 32'd0, lt ^ d[31], a < b};
  endfunction

  task automatic run_op(logic [3:0] f, logic [63:0] a, logic [63:0] b, bit m32, string mreq);
    bit ill = (f[3:2] == 2'b11);
    logic [63:0] em;
    in_valid = 1'b1; func = f; src_a = a; src_b = b; addr32 = m32;
    em = ill ? 64'd0 : {56'd0, ref_mask(int'(f[3:2]), f[1], a, b, m32)};
    if (!ill && !f[0]) begin
      exp_icc = ref_flags32(a[31:0], b[31:0]);
      exp_xcc = ref_flags64(a, b);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 valid", {63'd0, out_valid}, 64'd1);
    chk(ill ? "R12 mask" : mreq, mask_out, em);
    chk("R12 illegal", {63'd0, out_illegal}, {63'd0, ill});
    chk(f[0] || ill ? "R11 icc" : "R10 icc", {60'd0, icc}, {60'd0, exp_icc});
    chk(f[0] || ill ? "R11 xcc" : "R9 xcc", {60'd0, xcc}, {60'd0, exp_xcc});
  endtask

  function automatic string mask_tag(logic [3:0] f, bit same);
    if (!same) return "R6 mask";
    case (f[3:2])
      2'b00:   return f[1] ? "R3 mask" : "R2 mask";
      2'b01:   return "R4 mask";
      default: return "R5 mask";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] base;
    rst_n = 1'b0; in_valid = 1'b0; func = 4'h0; src_a = '0; src_b = '0; addr32 = 1'b0;
    repeat (3) @(negedge clk);
    // R13 reset values
    chk("R13 valid", {63'd0, out_valid}, 64'd0);
    chk("R13 mask", mask_out, 64'd0);
    chk("R13 flags", {56'd0, icc, xcc}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle", {63'd0, out_valid}, 64'd0);

    // R1 decode over all codes, all offset pairs, same word
    base = 64'h0123_4567_89ab_cde0;
    for (int f = 0; f < 16; f++)
      for (int s = 0; s < 8; s++)
        for (int e = 0; e < 8; e++)
          run_op(4'(f), base | 64'(s), base | 64'(e), 1'b0, mask_tag(4'(f), 1'b1));

    // R6 different words, both directions
    for (int f = 0; f < 12; f++)
      for (int s = 0; s < 8; s++) begin
        run_op(4'(f), 64'h1000 | 64'(s), 64'h2000 | 64'(7 - s), 1'b0, "R6 mask");
        run_op(4'(f), 64'h3008 | 64'(s), 64'h3000 | 64'(s), 1'b0, "R6 mask");
      end

    // R7 upper half differs only
    for (int f = 0; f < 12; f++)
      for (int s = 0; s < 8; s++) begin
        run_op(4'(f), 64'h0000_0001_0000_0040 | 64'(s),
               64'h8000_0000_0000_0040 | 64'(7 - s), 1'b1, "R7 mask");
        run_op(4'(f), 64'h0000_0001_0000_0040 | 64'(s),
               64'h8000_0000_0000_0040 | 64'(7 - s), 1'b0, "R6 mask");
      end

    // R9 R10 flag corner operands
    run_op(4'h0, 64'h8000_0000_0000_0000, 64'h1, 1'b0, "R2 mask");
    run_op(4'h5, 64'h5, 64'h9, 1'b0, "R4 mask");
    run_op(4'h0, 64'h7fff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 1'b0, "R6 mask");
    run_op(4'hC, 64'h1, 64'h2, 1'b0, "R12 mask");
    run_op(4'h2, 64'h0000_0001_8000_0000, 64'h0000_0000_0000_0001, 1'b0, "R6 mask");
    run_op(4'hB, 64'h0, 64'hffff, 1'b0, "R6 mask");
    run_op(4'h8, 64'h0000_0005_0000_0000, 64'h0000_0004_0000_0000, 1'b0, "R5 mask");
    run_op(4'hE, 64'h0, 64'h1, 1'b0, "R12 mask");
    run_op(4'h4, 64'h1234, 64'h1234, 1'b0, "R4 mask");

    @(negedge clk);
    chk("R8 idle mask", mask_out, 64'd0);
    chk("R11 idle flags", {56'd0, icc, xcc}, {56'd0, exp_icc, exp_xcc});
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule